// File: doc/BRIEF.md
# Multi-cycle 16-bit processor core

This block is a compact processor that keeps instructions and data in one 256-word by 16-bit memory. It holds a program counter, an instruction register, eight 16-bit general registers and a single ALU. A Moore state machine moves through fetch, decode and execute states. Loads and stores take extra execute states. The ALU is shared: it also advances the program counter during fetch and forms the branch target.

A program is written into memory through a load port while reset is held. Releasing reset starts execution at word 0. The processor runs until it reaches a halt instruction. The contents of the top memory word (address 255) are always shown on the display output, so a program reports results by storing to that word.

Load port rules: `ld_ready` is high exactly while `rst` is high. A word is written on each rising edge where `ld_valid` and `ld_ready` are both high. While the core is running, `ld_ready` stays low and `ld_valid` has no effect. A producer may hold `ld_valid` high for as many cycles as it likes.

Top module: `mc16_core`

## Requirements
- R1: While `rst` is high, the program counter and all eight registers are cleared, the controller sits in fetch, and `halted` is low. After release, the first instruction is fetched from word 0.
- R2: `ld_ready` is high exactly while `rst` is high. `ld_data` is written to word `ld_addr` on each edge with `ld_valid` and `ld_ready` both high. Outside reset, the load port changes no memory word.
- R3: The instruction fields are fixed at these bit positions:
  - opcode in [15:13];
  - rs in [12:10], rt in [9:7], rd in [6:4], funct in [3:0];
  - immediate in [6:0], a 7-bit two's-complement value sign-extended to 16 bits;
  - jump target in [12:0], zero-extended.
- R4: Opcode 0 writes rd from rs and rt, as selected by funct:
  - funct 0: rs+rt;
  - funct 1: rs-rt;
  - funct 2: rs&rt;
  - funct 3: rs|rt;
  - funct 4: 1 if rs<rt as signed numbers, else 0.
  This takes 3 cycles. Funct 5 to 15 write nothing and take 2 cycles.
- R5: Opcode 4 writes rt with rs plus the immediate, in 3 cycles.
- R6: The word address for a load or store is the low 8 bits of rs plus the immediate.
  - Opcode 1 loads that word into rt in 5 cycles.
  - Opcode 2 stores rt into that word in 4 cycles.
- R7: Opcode 3 takes 3 cycles. If rs equals rt, the next PC is the incremented PC plus the immediate; otherwise it is the incremented PC.
- R8: Opcode 5 sets the PC to the zero-extended target, in 3 cycles.
- R9: Opcode 6 does nothing and takes 2 cycles. Opcode 7 raises `halted` two cycles after its fetch starts. The core then holds all state, and `halted` stays high until reset.
- R10: `display` always equals the contents of memory word 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables program load |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load port accepts words (high during reset) |
| ld_addr | input | 8 | Memory word address for the load |
| ld_data | input | 16 | Data word to load |
| halted | output | 1 | Core has executed a halt |
| display | output | 16 | Contents of memory word 255 |

## Verification
The assertions assume that reset is high at the first clock edge and that memory is written only through the load port during reset or by store instructions. They also assume that every word the core fetches or loads was written beforehand. The stimulus holds reset while it loads each program. It loads word 255 with zero and runs only programs whose loads read words they stored first. It also keeps `ld_valid` high during one run to show that the port is ignored outside reset.

// File: rtl/mc16_pkg.sv
`timescale 1ns/1ps
package mc16_pkg;
  localparam int XLEN = 16;
  localparam int ADDR_W = 8;
  localparam int NUM_REGS = 8;

  typedef enum logic [2:0] {
    OPC_REG  = 3'd0,
    OPC_LOAD = 3'd1,
    OPC_STOR = 3'd2,
    OPC_BEQ  = 3'd3,
    OPC_ADDI = 3'd4,
    OPC_JUMP = 3'd5,
    OPC_NOP  = 3'd6,
    OPC_HALT = 3'd7
  } opc_e;

  typedef enum logic [2:0] {
    AL_ADD = 3'd0,
    AL_SUB = 3'd1,
    AL_AND = 3'd2,
    AL_OR  = 3'd3,
    AL_SLT = 3'd4
  } alu_e;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_EXREG, ST_EXIMM, ST_MADDR,
    ST_MREAD, ST_MWBACK, ST_MWRITE, ST_BRANCH, ST_JUMP, ST_HALT
  } state_e;
endpackage

// File: rtl/mc16_alu.sv
`timescale 1ns/1ps
module mc16_alu
  import mc16_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_e         op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      AL_SUB:  y = a - b;
      AL_AND:  y = a & b;
      AL_OR:   y = a | b;
      AL_SLT:  y = ($signed(a) < $signed(b)) ? W'(1) : '0;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/mc16_regfile.sv
`timescale 1ns/1ps
module mc16_regfile
  import mc16_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NUM_REGS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] waddr,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(N)-1:0] raddr_a,
  input  logic [$clog2(N)-1:0] raddr_b,
  output logic [W-1:0]         rdata_a,
  output logic [W-1:0]         rdata_b
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/mc16_mem.sv
`timescale 1ns/1ps
module mc16_mem
  import mc16_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  top_word
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata    = words[raddr];
  assign top_word = words[DEPTH-1];
endmodule

// File: rtl/mc16_ctrl.sv
`timescale 1ns/1ps
module mc16_ctrl
  import mc16_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] opcode,
  input  logic [3:0] funct,
  output state_e     st
);
  state_e st_nx;

  always_comb begin
    st_nx = ST_FETCH;
    case (st)
      ST_FETCH: st_nx = ST_DECODE;
      ST_DECODE: begin
        case (opc_e'(opcode))
          OPC_REG:  st_nx = (funct <= 4'd4) ? ST_EXREG : ST_FETCH;
          OPC_LOAD,
          OPC_STOR: st_nx = ST_MADDR;
          OPC_BEQ:  st_nx = ST_BRANCH;
          OPC_ADDI: st_nx = ST_EXIMM;
          OPC_JUMP: st_nx = ST_JUMP;
          OPC_HALT: st_nx = ST_HALT;
          default:  st_nx = ST_FETCH;
        endcase
      end
      ST_MADDR:  st_nx = (opc_e'(opcode) == OPC_LOAD) ? ST_MREAD : ST_MWRITE;
      ST_MREAD:  st_nx = ST_MWBACK;
      ST_HALT:   st_nx = ST_HALT;
      default:   st_nx = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_FETCH;
    else     st <= st_nx;
  end

  // R1: first cycle out of reset is a fetch
  a_r1_fetch_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> st == ST_FETCH);
  // R4: every fetch is followed by decode
  a_r4_decode_follows_fetch: assert property (@(posedge clk) disable iff (rst)
    st == ST_FETCH |=> st == ST_DECODE);
  // R6: a memory read always goes on to register writeback
  a_r6_read_then_writeback: assert property (@(posedge clk) disable iff (rst)
    st == ST_MREAD |=> st == ST_MWBACK);
  // R9: halt is held until reset
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    st == ST_HALT |=> st == ST_HALT);
endmodule

// File: rtl/mc16_core.sv
`timescale 1ns/1ps
module mc16_core
  import mc16_pkg::*;
#(
  parameter int W    = XLEN,
  parameter int AW   = ADDR_W,
  parameter int NREG = NUM_REGS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [W-1:0]  ld_data,
  output logic          halted,
  output logic [W-1:0]  display
);
  localparam int RIW = $clog2(NREG);
  localparam int IMM_W = 7;
  localparam int TGT_W = 13;

  state_e       st;
  logic [W-1:0] pc, ir, opa_q, opb_q, mar_q, mdr_q;
  logic [W-1:0] alu_a, alu_b, alu_y;
  alu_e         alu_op;
  logic [W-1:0] rf_a, rf_b, rf_wdata;
  logic         rf_we;
  logic [RIW-1:0] rf_waddr;
  logic         mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [W-1:0] mem_wdata, mem_rdata;

  // instruction fields
  logic [2:0]   f_op;
  logic [RIW-1:0] f_rs, f_rt, f_rd;
  logic [3:0]   f_funct;
  logic [W-1:0] imm_sx, tgt_zx;

  assign f_op    = ir[15:13];
  assign f_rs    = ir[12:10];
  assign f_rt    = ir[9:7];
  assign f_rd    = ir[6:4];
  assign f_funct = ir[3:0];
  assign imm_sx  = {{(W-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};
  assign tgt_zx  = {{(W-TGT_W){1'b0}}, ir[TGT_W-1:0]};

  mc16_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(f_op), .funct(f_funct), .st(st)
  );

  // shared ALU operand selection
  always_comb begin
    alu_a  = opa_q;
    alu_b  = opb_q;
    alu_op = AL_ADD;
    case (st)
      ST_FETCH:  begin alu_a = pc;    alu_b = W'(1); end
      ST_EXREG:  alu_op = alu_e'(f_funct[2:0]);
      ST_EXIMM,
      ST_MADDR:  alu_b = imm_sx;
      ST_BRANCH: begin alu_a = pc;    alu_b = imm_sx; end
      default:   ;
    endcase
  end

  mc16_alu #(.W(W)) u_alu (.op(alu_op), .a(alu_a), .b(alu_b), .y(alu_y));

  assign rf_we    = (st == ST_EXREG) || (st == ST_EXIMM) || (st == ST_MWBACK);
  assign rf_waddr = (st == ST_EXREG) ? f_rd : f_rt;
  assign rf_wdata = (st == ST_MWBACK) ? mdr_q : alu_y;

  mc16_regfile #(.W(W), .N(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr_a(f_rs), .raddr_b(f_rt), .rdata_a(rf_a), .rdata_b(rf_b)
  );

  assign ld_ready  = rst;
  assign mem_we    = (ld_valid && ld_ready) || (st == ST_MWRITE && !rst);
  assign mem_waddr = rst ? ld_addr : mar_q[AW-1:0];
  assign mem_wdata = rst ? ld_data : opb_q;
  assign mem_raddr = (st == ST_FETCH) ? pc[AW-1:0] : mar_q[AW-1:0];

  mc16_mem #(.W(W), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata), .top_word(display)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      ir    <= '0;
      opa_q <= '0;
      opb_q <= '0;
      mar_q <= '0;
      mdr_q <= '0;
    end else begin
      case (st)
        ST_FETCH:  begin ir <= mem_rdata; pc <= alu_y; end
        ST_DECODE: begin opa_q <= rf_a; opb_q <= rf_b; end
        ST_MADDR:  mar_q <= alu_y;
        ST_MREAD:  mdr_q <= mem_rdata;
        ST_BRANCH: if (opa_q == opb_q) pc <= alu_y;
        ST_JUMP:   pc <= tgt_zx;
        default:   ;
      endcase
    end
  end

  assign halted = (st == ST_HALT);

  // R9: nothing advances the PC once halted
  a_r9_pc_frozen: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc));
  // R10: display changes only through a write to the top word
  a_r10_display_hold: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && (&mem_waddr)) |=> $stable(display));
  // R2: the load port never writes memory while running
  a_r2_no_load_running: assert property (@(posedge clk) disable iff (rst)
    (mem_we && st != ST_MWRITE) |-> ld_ready);
endmodule

// File: tb/sim_mc16_core.sv
`timescale 1ns/1ps
module sim_mc16_core;
  logic        clk = 0;
  logic        rst = 1;
  logic        ld_valid = 0;
  logic        ld_ready;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        halted;
  logic [15:0] display;

  int n_chk = 0;
  int n_bad = 0;

  mc16_core u0 (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .halted(halted), .display(display)
  );

  always #2.5 clk = ~clk;

  // reference model state
  logic [15:0] prog [0:31];
  int          plen;
  logic [15:0] mmem [0:255];
  logic [15:0] mreg [0:7];
  logic [15:0] mpc, cur;
  int          cnt;
  bit          mhalt;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] enc_r(int rs, int rt, int rd, int fn);
    return {3'd0, 3'(rs), 3'(rt), 3'(rd), 4'(fn)};
  endfunction
  function automatic logic [15:0] enc_i(int op, int rs, int rt, int imm);
    return {3'(op), 3'(rs), 3'(rt), 7'(imm)};
  endfunction
  function automatic logic [15:0] enc_j(int op, int tgt);
    return {3'(op), 13'(tgt)};
  endfunction

  function automatic int ilen(logic [15:0] w);
    case (w[15:13])
      3'd0: return (w[3:0] <= 4'd4) ? 3 : 2;
      3'd1: return 5;
      3'd2: return 4;
      3'd3, 3'd4, 3'd5: return 3;
      default: return 2;
    endcase
  endfunction

  task automatic mexec(input logic [15:0] w);
    logic [15:0] s, t, imm;
    s = mreg[w[12:10]];
    t = mreg[w[9:7]];
    imm = {{9{w[6]}}, w[6:0]};
    mpc = mpc + 16'd1;
    case (w[15:13])
      3'd0: case (w[3:0])
        4'd0: mreg[w[6:4]] = s + t;
        4'd1: mreg[w[6:4]] = s - t;
        4'd2: mreg[w[6:4]] = s & t;
        4'd3: mreg[w[6:4]] = s | t;
        4'd4: mreg[w[6:4]] = ($signed(s) < $signed(t)) ? 16'd1 : 16'd0;
        default: ;
      endcase
      3'd1: mreg[w[9:7]] = mmem[8'(s + imm)];
      3'd2: mmem[8'(s + imm)] = t;
      3'd3: if (s == t) mpc = mpc + imm;
      3'd4: mreg[w[9:7]] = s + imm;
      3'd5: mpc = {3'd0, w[12:0]};
      3'd7: mhalt = 1;
      default: ;
    endcase
  endtask

  task automatic mstep();
    if (mhalt) return;
    if (cnt == 0) cur = mmem[mpc[7:0]];
    cnt++;
    if (cnt == ilen(cur)) begin
      mexec(cur);
      cnt = 0;
    end
  endtask

  task automatic run(input string tag, input bit poke_port, input logic [15:0] exp_final);
    int extra;
    rst = 1;
    @(negedge clk);
    chk(ld_ready === 1'b1, "R2 ready in reset", 16'(ld_ready), 16'd1);
    chk(halted === 1'b0, "R1 halted low in reset", 16'(halted), 16'd0);
    for (int i = 0; i < 256; i++) mmem[i] = '0;
    for (int i = 0; i < 8; i++) mreg[i] = '0;
    for (int i = 0; i <= plen; i++) begin
      ld_valid = 1;
      ld_addr  = (i == plen) ? 8'd255 : 8'(i);
      ld_data  = (i == plen) ? 16'd0 : prog[i];
      if (i < plen) mmem[i] = prog[i];
      @(negedge clk);
    end
    ld_valid = 0;
    mpc = 0; cnt = 0; mhalt = 0;
    chk(display === 16'd0, "R10 display after load", display, 16'd0);
    rst = 0;
    if (poke_port) begin
      // R2: offer words while running; they must be refused
      ld_valid = 1; ld_addr = 8'd255; ld_data = 16'hDEAD;
    end
    chk(ld_ready === 1'b0, "R2 ready low when running", 16'(ld_ready), 16'd0);
    extra = 0;
    for (int c = 0; c < 4000 && extra < 8; c++) begin
      @(posedge clk);
      mstep();
      @(negedge clk);
      chk(halted === mhalt, {tag, " halted"}, 16'(halted), 16'(mhalt));
      chk(display === mmem[255], {tag, " display"}, display, mmem[255]);
      if (mhalt) extra++;
    end
    ld_valid = 0;
    chk(halted === 1'b1, {"R9 final halt ", tag}, 16'(halted), 16'd1);
    chk(display === exp_final, {"R10 final display ", tag}, display, exp_final);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // Program A: R3 R4 R5 R10 with load port poked while running (R2)
    prog[0]  = enc_i(4, 0, 1, 5);
    prog[1]  = enc_i(4, 0, 2, -3);
    prog[2]  = enc_i(4, 0, 6, -1);
    prog[3]  = enc_r(1, 2, 3, 0);  prog[4]  = enc_i(2, 6, 3, 0);
    prog[5]  = enc_r(1, 2, 3, 1);  prog[6]  = enc_i(2, 6, 3, 0);
    prog[7]  = enc_r(1, 2, 3, 2);  prog[8]  = enc_i(2, 6, 3, 0);
    prog[9]  = enc_r(1, 2, 3, 3);  prog[10] = enc_i(2, 6, 3, 0);
    prog[11] = enc_r(1, 2, 3, 4);  prog[12] = enc_i(2, 6, 3, 0);
    prog[13] = enc_r(2, 1, 3, 4);  prog[14] = enc_i(2, 6, 3, 0);
    prog[15] = enc_j(7, 0);
    plen = 16;
    run("R4 R5 R2 alu", 1'b1, 16'd1);

    // Program B: loop with branch and jump (R7 R8), memory (R6), nop (R9)
    prog[0]  = enc_i(4, 0, 1, 3);
    prog[1]  = enc_i(4, 0, 6, -1);
    prog[2]  = enc_i(4, 0, 2, 0);
    prog[3]  = enc_r(2, 1, 2, 0);
    prog[4]  = enc_i(4, 1, 1, -1);
    prog[5]  = enc_i(3, 1, 0, 1);
    prog[6]  = enc_j(5, 3);
    prog[7]  = enc_i(2, 0, 2, 40);
    prog[8]  = enc_i(1, 0, 3, 40);
    prog[9]  = enc_i(4, 3, 3, 1);
    prog[10] = enc_i(2, 6, 3, 0);
    prog[11] = enc_j(6, 0);
    prog[12] = enc_r(6, 6, 3, 9);
    prog[13] = enc_i(4, 3, 3, 1);
    prog[14] = enc_i(2, 6, 3, 0);
    prog[15] = enc_j(7, 0);
    prog[16] = enc_i(2, 6, 1, 0);
    plen = 17;
    run("R6 R7 R8 R9 flow", 1'b0, 16'd8);

    // Program C: backward branch, negative memory offset (R7 R6 R1 after halt)
    prog[0]  = enc_i(4, 0, 6, -1);
    prog[1]  = enc_i(4, 0, 1, 2);
    prog[2]  = enc_i(4, 1, 1, -1);
    prog[3]  = enc_i(2, 6, 1, 0);
    prog[4]  = enc_i(3, 1, 0, 1);
    prog[5]  = enc_i(3, 0, 0, -4);
    prog[6]  = enc_i(4, 0, 4, 50);
    prog[7]  = enc_i(2, 4, 4, -10);
    prog[8]  = enc_i(1, 4, 5, -10);
    prog[9]  = enc_i(2, 6, 5, 0);
    prog[10] = enc_j(5, 12);
    prog[11] = enc_j(7, 0);
    prog[12] = enc_i(4, 5, 2, 9);
    prog[13] = enc_i(2, 6, 2, 0);
    prog[14] = enc_j(7, 0);
    plen = 15;
    run("R1 R3 R6 R7 branch", 1'b0, 16'd59);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule